// File: doc/BRIEF.md
# Posted-Write Memory with Read Forwarding

This block wraps a synchronous single-port memory so that a write never has to use the array in the cycle it is issued. Each accepted write is parked in a one-entry holding register together with its address and per-lane byte enables. The parked write is copied into the array only when the next write command arrives, and that newer write takes its place in the register. Any number of reads may pass between the two writes. While they do, the parked write stays in the register and the array does not change.

A read compares its address with the parked entry. On a match, every lane whose enable bit was set comes from the register and every other lane comes from the array. Reads therefore always return the most recently written value. Read results leave through a short pipeline. In the normal setting it is two stages deep. When the short-latency control is high it is one stage deep. The valid flag goes through the same registers as the data.

The command side has no back-pressure. A command is taken on every rising edge where the strobe is high, so the block needs no ready signal. The read result port is also push-only: the consumer must take each result in the cycle its valid flag is high. The latency control may be changed only when no read is in flight.

Top module: `pwr_top`

## Requirements
- R1: A write command (cmd_valid=1, cmd_write=1) updates the stored word at cmd_addr. Only the lanes l whose cmd_be[l] is 1 change, where lane l is bits [8l+7:8l]. Every later read of that address reflects the update.
- R2: A read issued in the cycle right after a full-lane write to the same address returns the new word, not the older array contents.
- R3: When the parked write had only some lanes enabled, a read that matches its address returns the held bytes in the enabled lanes and the array bytes in the others.
- R4: A parked write survives any number of consecutive read cycles. Reads to other addresses return the array contents during that time.
- R5: Writes issued on consecutive cycles all take effect. This includes two partial writes to the same address with different lanes: both sets of lanes end up stored.
- R6: A cycle with cmd_valid=0 is a no-operation, whatever cmd_write, cmd_addr, cmd_wdata and cmd_be carry. It changes neither the stored data nor the parked write.
- R7: While rst_n is low, rd_valid and rd_data are 0. Reset discards a parked write that was never committed, so afterwards its address reads back the last committed value. No commit happens until a write has been parked.
- R8: With lat_short=0, the result of a read accepted at edge N is on rd_data with rd_valid=1 after edge N+2. In every cycle that carries no result, rd_valid is 0 and rd_data is 0.
- R9: With lat_short=1, the result of a read accepted at edge N appears with rd_valid=1 after edge N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command strobe; low means no-operation |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 6 | Word address |
| cmd_wdata | input | 32 | Write data, four 8-bit lanes |
| cmd_be | input | 4 | Lane enables for a write |
| lat_short | input | 1 | 1 = one-cycle read latency, 0 = two-cycle |
| rd_data | output | 32 | Read result, zero when not valid |
| rd_valid | output | 1 | Read result valid |

## Verification
Two things can happen in the same cycle: the commit of the parked write to the array, and the parking of a new write at that same address. The bench provokes this with two partial writes to one address on back-to-back cycles, each enabling different lanes. It then reads the address while the second write is still parked. The result is judged against a bench model in which every write lands at once, so the returned word must show both lane sets: one set taken from the array and the other forwarded from the register.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  localparam int unsigned PWR_ADDR_W = 6;
  localparam int unsigned PWR_LANES  = 4;
  localparam int unsigned PWR_LANE_W = 8;

  typedef enum logic {
    LAT_NORMAL = 1'b0,
    LAT_SHORT  = 1'b1
  } lat_mode_e;
endpackage

// File: rtl/pwr_array.sv
module pwr_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        waddr,
  input  logic [LANES*LANE_W-1:0]  wdata,
  input  logic [LANES-1:0]         wbe,
  input  logic [ADDR_W-1:0]        raddr,
  output logic [LANES*LANE_W-1:0]  rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wbe[l]) begin
        cells[waddr] <= wdata[l*LANE_W +: LANE_W];
      end
    end

    assign rdata[l*LANE_W +: LANE_W] = cells[raddr];
  end
endmodule

// File: rtl/pwr_post.sv
module pwr_post #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     post_en,
  input  logic [ADDR_W-1:0]        in_addr,
  input  logic [LANES*LANE_W-1:0]  in_data,
  input  logic [LANES-1:0]         in_be,
  output logic                     pend_vld,
  output logic [ADDR_W-1:0]        pend_addr,
  output logic [LANES*LANE_W-1:0]  pend_data,
  output logic [LANES-1:0]         pend_be,
  output logic                     commit_en
);
  // A new post retires whatever is parked in the same cycle.
  assign commit_en = post_en && pend_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
      pend_be   <= '0;
    end else if (post_en) begin
      pend_vld  <= 1'b1;
      pend_addr <= in_addr;
      pend_data <= in_data;
      pend_be   <= in_be;
    end
  end

  AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !post_en |=> $stable(pend_vld) && $stable(pend_addr) && $stable(pend_data) && $stable(pend_be)); // R4

  AST_POST_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_vld) |-> $past(post_en)); // R7
endmodule

// File: rtl/pwr_fwd.sv
module pwr_fwd #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8
) (
  input  logic [ADDR_W-1:0]        raddr,
  input  logic [LANES*LANE_W-1:0]  arr_data,
  input  logic                     pend_vld,
  input  logic [ADDR_W-1:0]        pend_addr,
  input  logic [LANES*LANE_W-1:0]  pend_data,
  input  logic [LANES-1:0]         pend_be,
  output logic [LANES*LANE_W-1:0]  out_data
);
  logic hit;
  assign hit = pend_vld && (raddr == pend_addr);

  for (genvar l = 0; l < LANES; l++) begin : g_merge
    assign out_data[l*LANE_W +: LANE_W] = (hit && pend_be[l]) ?
        pend_data[l*LANE_W +: LANE_W] : arr_data[l*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/pwr_rdpipe.sv
module pwr_rdpipe
  import pwr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  lat_mode_e          mode,
  input  logic               in_vld,
  input  logic [DATA_W-1:0]  in_data,
  output logic               out_vld,
  output logic [DATA_W-1:0]  out_data
);
  logic              s1_vld, s2_vld;
  logic [DATA_W-1:0] s1_data, s2_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_data <= '0;
      s2_vld  <= 1'b0;
      s2_data <= '0;
    end else begin
      s1_vld  <= in_vld;
      s1_data <= in_vld ? in_data : '0;
      s2_vld  <= s1_vld;
      s2_data <= s1_data;
    end
  end

  assign out_vld  = (mode == LAT_SHORT) ? s1_vld  : s2_vld;
  assign out_data = (mode == LAT_SHORT) ? s1_data : s2_data;

  AST_LAT_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && mode == LAT_NORMAL ##1 mode == LAT_NORMAL |=> out_vld); // R8

  AST_LAT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && mode == LAT_SHORT |=> out_vld); // R9
endmodule

// File: rtl/pwr_top.sv
module pwr_top
  import pwr_pkg::*;
#(
  parameter int unsigned ADDR_W = PWR_ADDR_W,
  parameter int unsigned LANES  = PWR_LANES,
  parameter int unsigned LANE_W = PWR_LANE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic                     cmd_write,
  input  logic [ADDR_W-1:0]        cmd_addr,
  input  logic [LANES*LANE_W-1:0]  cmd_wdata,
  input  logic [LANES-1:0]         cmd_be,
  input  logic                     lat_short,
  output logic [LANES*LANE_W-1:0]  rd_data,
  output logic                     rd_valid
);
  localparam int unsigned DATA_W = LANES * LANE_W;

  logic              cmd_rd, cmd_wr;
  logic              pend_vld, commit_en;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data, arr_rdata, fwd_data;
  logic [LANES-1:0]  pend_be;
  lat_mode_e         mode;

  assign cmd_rd = cmd_valid && !cmd_write;
  assign cmd_wr = cmd_valid && cmd_write;
  assign mode   = lat_mode_e'(lat_short);

  pwr_post #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_post (
    .clk(clk), .rst_n(rst_n), .post_en(cmd_wr),
    .in_addr(cmd_addr), .in_data(cmd_wdata), .in_be(cmd_be),
    .pend_vld(pend_vld), .pend_addr(pend_addr), .pend_data(pend_data),
    .pend_be(pend_be), .commit_en(commit_en)
  );

  pwr_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .we(commit_en), .waddr(pend_addr), .wdata(pend_data),
    .wbe(pend_be), .raddr(cmd_addr), .rdata(arr_rdata)
  );

  pwr_fwd #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_fwd (
    .raddr(cmd_addr), .arr_data(arr_rdata), .pend_vld(pend_vld),
    .pend_addr(pend_addr), .pend_data(pend_data), .pend_be(pend_be),
    .out_data(fwd_data)
  );

  pwr_rdpipe #(.DATA_W(DATA_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_vld(cmd_rd),
    .in_data(fwd_data), .out_vld(rd_valid), .out_data(rd_data)
  );

  AST_FWD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rd && lat_short && pend_vld && cmd_addr == pend_addr && (&pend_be)
    |=> rd_data == $past(pend_data)); // R2

  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rd_valid || !lat_short); // R6
endmodule

// File: tb/tb_pwr_top.sv
module tb_pwr_top;
  localparam int AW = 6;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_write = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic [3:0]    cmd_be = '0;
  logic          lat_short = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;

  pwr_top dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_be(cmd_be),
    .lat_short(lat_short), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [DW-1:0] model [64];
  bit            exp_v [8];
  logic [DW-1:0] exp_d [8];
  string         exp_tag [8];

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    for (int i = 0; i < 8; i++) begin
      exp_v[i] = 1'b0; exp_d[i] = '0; exp_tag[i] = "R8";
    end
  end

  // Result monitor: compares outputs with the expected slot for this cycle.
  always @(negedge clk) begin
    int s;
    s = cyc % 8;
    checks++;
    if (rd_valid !== exp_v[s]) begin
      errors++;
      $display("FAIL %s rd_valid at cycle %0d: got %0b expected %0b", exp_tag[s], cyc, rd_valid, exp_v[s]);
    end else if (exp_v[s] && rd_data !== exp_d[s]) begin
      errors++;
      $display("FAIL %s rd_data at cycle %0d: got %h expected %h", exp_tag[s], cyc, rd_data, exp_d[s]);
    end else if (!exp_v[s] && rd_data !== '0) begin
      errors++;
      $display("FAIL R8 idle rd_data at cycle %0d: got %h expected 0", cyc, rd_data);
    end
    exp_v[s] = 1'b0;
    exp_tag[s] = "R8";
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [3:0] be);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = a; cmd_wdata = d; cmd_be = be;
    for (int l = 0; l < 4; l++) if (be[l]) model[a][l*8 +: 8] = d[l*8 +: 8];
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    int s;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = a; cmd_wdata = 32'hDEAD_BEEF; cmd_be = 4'hF;
    s = (cyc + (lat_short ? 1 : 2)) % 8;
    exp_v[s] = 1'b1; exp_d[s] = model[a]; exp_tag[s] = tag;
  endtask

  task automatic nop(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_write = 1'b1; cmd_addr = a; cmd_wdata = d; cmd_be = 4'hF;
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) nop(6'd0, 32'h0);
  endtask

  task automatic t_reset_state();
    checks++;
    if (rd_valid !== 1'b0 || rd_data !== '0) begin
      errors++;
      $display("FAIL R7 reset outputs: got v=%0b d=%h expected v=0 d=0", rd_valid, rd_data);
    end
  endtask

  task automatic t_fill();
    for (int i = 0; i < 16; i++) wr(i[AW-1:0], 32'h1000_0000 + i * 32'h0101_0101, 4'hF);
    for (int i = 0; i < 16; i++) rd(i[AW-1:0], "R1");
    drain();
  endtask

  task automatic t_fwd_full();
    wr(6'd3, 32'hA5A5_0303, 4'hF);
    rd(6'd3, "R2");
    rd(6'd3, "R2");
    wr(6'd4, 32'h0404_C3C3, 4'hF);
    rd(6'd4, "R2");
    drain();
  endtask

  task automatic t_fwd_partial();
    wr(6'd5, 32'hEE11_EE22, 4'b0101);
    rd(6'd5, "R3");
    wr(6'd6, 32'h77FF_0000, 4'b1010);
    rd(6'd6, "R3");
    rd(6'd5, "R3");
    drain();
  endtask

  task automatic t_hold_reads();
    wr(6'd7, 32'h7777_0007, 4'hF);
    rd(6'd8, "R4"); rd(6'd9, "R4"); rd(6'd7, "R4");
    rd(6'd10, "R4"); rd(6'd7, "R4"); rd(6'd11, "R4");
    nop(6'd7, 32'h0);
    rd(6'd7, "R4");
    wr(6'd12, 32'hCCCC_0012, 4'hF);
    rd(6'd7, "R4"); rd(6'd12, "R4");
    drain();
  endtask

  task automatic t_back_to_back();
    wr(6'd20, 32'h2020_2020, 4'hF);
    wr(6'd21, 32'h2121_2121, 4'hF);
    wr(6'd22, 32'h2222_2222, 4'hF);
    wr(6'd20, 32'h0000_ABCD, 4'b0011);
    wr(6'd20, 32'h9876_0000, 4'b1100);
    rd(6'd20, "R5"); rd(6'd21, "R5"); rd(6'd22, "R5");
    wr(6'd23, 32'h2323_2323, 4'hF);
    rd(6'd20, "R5");
    drain();
  endtask

  task automatic t_nop();
    wr(6'd30, 32'h3030_3030, 4'hF);
    nop(6'd30, 32'hFFFF_FFFF);
    nop(6'd31, 32'hEEEE_EEEE);
    rd(6'd30, "R6");
    wr(6'd32, 32'h3232_3232, 4'hF);
    nop(6'd30, 32'h1111_1111);
    rd(6'd30, "R6"); rd(6'd32, "R6");
    drain();
  endtask

  task automatic t_low_lat();
    @(negedge clk); lat_short = 1'b1; cmd_valid = 1'b0;
    rd(6'd3, "R9");
    wr(6'd40, 32'h4040_ABAB, 4'hF);
    rd(6'd40, "R9");
    wr(6'd40, 32'h00FF_0000, 4'b0100);
    rd(6'd40, "R9"); rd(6'd5, "R9");
    drain();
    @(negedge clk); lat_short = 1'b0;
    rd(6'd40, "R8");
    drain();
  endtask

  task automatic t_reset_drop();
    wr(6'd50, 32'h5050_0001, 4'hF);
    wr(6'd51, 32'h5151_0001, 4'hF);
    wr(6'd50, 32'h5050_0002, 4'hF);
    drain();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); #0;
    t_reset_state();
    @(negedge clk); rst_n = 1'b1;
    model[50] = 32'h5050_0001;
    rd(6'd50, "R7"); rd(6'd51, "R7");
    drain();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    t_fill();
    t_fwd_full();
    t_fwd_partial();
    t_hold_reads();
    t_back_to_back();
    t_nop();
    t_low_lat();
    t_reset_drop();
    finish_run();
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    finish_run();
  end
endmodule